// File: doc/BRIEF.md
# Dual-Set Index Register Unit

This unit is the register file behind address formation in a 36-bit word processor. It holds two complete register sets: a user set and an executive set. Each set has sixteen index registers, sixteen arithmetic registers and sixteen scratch registers. Every index register word carries two 18-bit fields. The low field is an offset used to form an address. The high field is a step that can be added to the offset once the offset has been used, so a loop advances its pointer without a separate add. The last four index registers share storage with the first four arithmetic registers. A register number therefore reaches the same word whether it is named as an index or as an arithmetic register.

A one-bit set selector chooses the set that instructions use. The unit holds this bit itself. An interrupt forces it to the executive value, and the processor may also load it directly. Register contents can be reached in two ways. The first is by register form, which is class plus number within the current set. The second is as a small data address inside a 128-word window, where one address bit names the set explicitly. This lets data references to the low words of the instruction bank be served from the register file. When non-privileged code writes any executive register, the write is dropped and a one-cycle fault pulse is raised. Reads of the executive set from user mode are allowed.

All results are registered and appear one clock after the request.

Top module: `xr_dual_set_unit`

## Requirements
- R1: After synchronous reset, every register of both sets reads zero. The set selector is 1 (executive). `fault_o`, `xa_vld_o` and `rd_vld_o` are 0.
- R2: When `xa_en_i` is 1, `xa_vld_o` is 1 in the next cycle. `xa_ofs_o` then carries bits [17:0] of index register `xa_num_i` in the set selected at request time. Without `xa_en_i`, `xa_vld_o` is 0 in the next cycle.
- R3: When `xa_en_i` and `xa_inc_i` are both 1, `xa_ofs_o` returns the offset from before the update. The stored word becomes {step, (offset + step) mod 2^18}, with step = bits [35:18]. Bits [35:18] keep their value.
- R4: Arithmetic registers 0 to 3 are the same storage as index registers 12 to 15 of the same set. Arithmetic registers 4 to 15 and all scratch registers are separate words.
- R5: `irq_i` sets the selector to 1 in the next cycle and overrides `setld_en_i`. Otherwise `setld_en_i` loads `setld_val_i`. `set_o` shows the selector.
- R6: The two sets are independent storage. Register-form accesses and `xa` requests use the selector value of the request cycle.
- R7: Data-port address encoding: bits [5:4] give the class (0 index, 1 arithmetic, 2 scratch, 3 unused) and bits [3:0] give the number. With `dp_win_i`=1, bit [6] names the set (1 executive). With `dp_win_i`=0, the current selector names the set. Class 3 reads return zero and class 3 writes change nothing.
- R8: A data-port write to the executive set while `user_mode_i`=1 raises `fault_o` for exactly the next cycle and changes no register. Reads of the executive set in user mode return data without a fault.
- R9: When one cycle both writes and post-increments the same index register, the written value is what remains stored.
- R10: When `dp_en_i`=1 and `dp_we_i`=0, `rd_vld_o` is 1 in the next cycle and `rd_data_o` carries the addressed word. A read in the cycle after a write returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 1 | Interrupt: force selector to executive |
| setld_en_i | input | 1 | Load the set selector |
| setld_val_i | input | 1 | Selector value to load |
| user_mode_i | input | 1 | Request comes from non-privileged code |
| xa_en_i | input | 1 | Address-formation request |
| xa_num_i | input | 4 | Index register number for address formation |
| xa_inc_i | input | 1 | Add step to offset after use |
| dp_en_i | input | 1 | Data-port access |
| dp_we_i | input | 1 | Data-port write (else read) |
| dp_win_i | input | 1 | Address is a window address with explicit set bit |
| dp_addr_i | input | 7 | {set, class[1:0], number[3:0]} |
| dp_wdata_i | input | 36 | Write data |
| set_o | output | 1 | Current set selector |
| xa_vld_o | output | 1 | `xa_ofs_o` valid |
| xa_ofs_o | output | 18 | Offset for address formation |
| rd_vld_o | output | 1 | `rd_data_o` valid |
| rd_data_o | output | 36 | Read data |
| fault_o | output | 1 | Privilege fault pulse |

## Verification
Assertions check on every cycle that the fault pulse and both valid flags follow their requests one cycle later. They check that an interrupt always leaves the executive set selected, and that a post-increment never disturbs the step field. Other behaviours are visible only in the bench scenarios: the alias between arithmetic 0 to 3 and index 12 to 15, the separation of the two sets, offset wraparound, and write priority over increment. The bench also shows that a faulted write leaves contents untouched and that class 3 reads zero. These depend on stored contents read back later, so a reference model drives random traffic alongside the directed corner cases.

// File: rtl/xr_pkg.sv
package xr_pkg;
  typedef enum logic [1:0] {
    CLS_X    = 2'd0,
    CLS_A    = 2'd1,
    CLS_R    = 2'd2,
    CLS_NONE = 2'd3
  } reg_cls_e;
endpackage

// File: rtl/xr_setbit.sv
module xr_setbit (
  input  logic clk,
  input  logic rst,
  input  logic irq_i,
  input  logic ld_en_i,
  input  logic ld_val_i,
  output logic set_o
);
  logic set_q;

  always_ff @(posedge clk) begin
    if (rst)          set_q <= 1'b1;
    else if (irq_i)   set_q <= 1'b1;
    else if (ld_en_i) set_q <= ld_val_i;
  end

  assign set_o = set_q;

  // R5
  irq_forces_exec_chk: assert property (@(posedge clk) disable iff (rst)
    $past(irq_i) |-> set_q);
endmodule

// File: rtl/xr_map.sv
module xr_map
  import xr_pkg::*;
#(
  parameter int NUM_W     = 4,
  parameter int ALIAS_CNT = 4,
  parameter int PHYS      = 3 * (1 << NUM_W) - ALIAS_CNT,
  parameter int IDX_W     = $clog2(2 * PHYS)
) (
  input  reg_cls_e             cls_i,
  input  logic [NUM_W-1:0]     num_i,
  input  logic                 set_i,
  output logic                 valid_o,
  output logic [IDX_W-1:0]     idx_o
);
  localparam int NREG   = 1 << NUM_W;
  localparam int A_BASE = NREG - ALIAS_CNT;
  localparam int R_BASE = 2 * NREG - ALIAS_CNT;

  logic [IDX_W-1:0] phys;

  always_comb begin
    valid_o = 1'b1;
    case (cls_i)
      CLS_X:   phys = IDX_W'(num_i);
      CLS_A:   phys = IDX_W'(num_i) + IDX_W'(A_BASE);
      CLS_R:   phys = IDX_W'(num_i) + IDX_W'(R_BASE);
      default: begin
        phys    = '0;
        valid_o = 1'b0;
      end
    endcase
    idx_o = set_i ? phys + IDX_W'(PHYS) : phys;
  end
endmodule

// File: rtl/xr_store.sv
module xr_store #(
  parameter int WORD_W = 36,
  parameter int OFS_W  = 18,
  parameter int DEPTH  = 88,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xa_en_i,
  input  logic              inc_en_i,
  input  logic [IDX_W-1:0]  xa_idx_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic              rd_valid_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [OFS_W-1:0]  xa_ofs_o,
  output logic [WORD_W-1:0] rd_data_o
);
  localparam int STEP_W = WORD_W - OFS_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] xa_word;
  logic [OFS_W-1:0]  bumped;
  logic [OFS_W-1:0]  xa_q;
  logic [WORD_W-1:0] rd_q;

  assign xa_word = mem[xa_idx_i];
  assign bumped  = xa_word[OFS_W-1:0] + OFS_W'(xa_word[WORD_W-1:OFS_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      xa_q <= '0;
      rd_q <= '0;
    end else begin
      if (xa_en_i) xa_q <= xa_word[OFS_W-1:0];
      if (rd_en_i) rd_q <= rd_valid_i ? mem[rd_idx_i] : '0;
      if (inc_en_i) mem[xa_idx_i] <= {xa_word[WORD_W-1:OFS_W], bumped};
      if (wr_en_i)  mem[wr_idx_i] <= wr_data_i;
    end
  end

  assign xa_ofs_o  = xa_q;
  assign rd_data_o = rd_q;

  logic              chk_live_q;
  logic [IDX_W-1:0]  chk_idx_q;
  logic [STEP_W-1:0] chk_step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_live_q <= 1'b0;
      chk_idx_q  <= '0;
      chk_step_q <= '0;
    end else begin
      chk_live_q <= inc_en_i && !(wr_en_i && wr_idx_i == xa_idx_i);
      chk_idx_q  <= xa_idx_i;
      chk_step_q <= xa_word[WORD_W-1:OFS_W];
    end
  end

  // R3
  step_kept_chk: assert property (@(posedge clk) disable iff (rst)
    chk_live_q |-> mem[chk_idx_q][WORD_W-1:OFS_W] == chk_step_q);
endmodule

// File: rtl/xr_dual_set_unit.sv
module xr_dual_set_unit
  import xr_pkg::*;
#(
  parameter int WORD_W    = 36,
  parameter int OFS_W     = 18,
  parameter int NUM_W     = 4,
  parameter int ALIAS_CNT = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   irq_i,
  input  logic                   setld_en_i,
  input  logic                   setld_val_i,
  input  logic                   user_mode_i,
  input  logic                   xa_en_i,
  input  logic [NUM_W-1:0]       xa_num_i,
  input  logic                   xa_inc_i,
  input  logic                   dp_en_i,
  input  logic                   dp_we_i,
  input  logic                   dp_win_i,
  input  logic [NUM_W+2:0]       dp_addr_i,
  input  logic [WORD_W-1:0]      dp_wdata_i,
  output logic                   set_o,
  output logic                   xa_vld_o,
  output logic [OFS_W-1:0]       xa_ofs_o,
  output logic                   rd_vld_o,
  output logic [WORD_W-1:0]      rd_data_o,
  output logic                   fault_o
);
  localparam int WIN_W = NUM_W + 3;
  localparam int PHYS  = 3 * (1 << NUM_W) - ALIAS_CNT;
  localparam int DEPTH = 2 * PHYS;
  localparam int IDX_W = $clog2(DEPTH);

  logic set_q;

  xr_setbit u_setbit (
    .clk      (clk),
    .rst      (rst),
    .irq_i    (irq_i),
    .ld_en_i  (setld_en_i),
    .ld_val_i (setld_val_i),
    .set_o    (set_q)
  );

  logic             dp_set;
  reg_cls_e         dp_cls;
  logic [NUM_W-1:0] dp_num;
  logic             dp_valid;
  logic [IDX_W-1:0] dp_idx;
  logic             xa_valid;
  logic [IDX_W-1:0] xa_idx;

  assign dp_set = dp_win_i ? dp_addr_i[WIN_W-1] : set_q;
  assign dp_cls = reg_cls_e'(dp_addr_i[NUM_W+1:NUM_W]);
  assign dp_num = dp_addr_i[NUM_W-1:0];

  xr_map #(.NUM_W(NUM_W), .ALIAS_CNT(ALIAS_CNT), .PHYS(PHYS), .IDX_W(IDX_W)) u_dp_map (
    .cls_i   (dp_cls),
    .num_i   (dp_num),
    .set_i   (dp_set),
    .valid_o (dp_valid),
    .idx_o   (dp_idx)
  );

  xr_map #(.NUM_W(NUM_W), .ALIAS_CNT(ALIAS_CNT), .PHYS(PHYS), .IDX_W(IDX_W)) u_xa_map (
    .cls_i   (CLS_X),
    .num_i   (xa_num_i),
    .set_i   (set_q),
    .valid_o (xa_valid),
    .idx_o   (xa_idx)
  );

  logic is_wr, is_rd, priv_viol, store_we;

  assign is_wr     = dp_en_i && dp_we_i;
  assign is_rd     = dp_en_i && !dp_we_i;
  assign priv_viol = is_wr && user_mode_i && dp_set;
  assign store_we  = is_wr && !priv_viol && dp_valid;

  xr_store #(.WORD_W(WORD_W), .OFS_W(OFS_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .xa_en_i    (xa_en_i && xa_valid),
    .inc_en_i   (xa_en_i && xa_inc_i && xa_valid),
    .xa_idx_i   (xa_idx),
    .wr_en_i    (store_we),
    .wr_idx_i   (dp_idx),
    .wr_data_i  (dp_wdata_i),
    .rd_en_i    (is_rd),
    .rd_valid_i (dp_valid),
    .rd_idx_i   (dp_idx),
    .xa_ofs_o   (xa_ofs_o),
    .rd_data_o  (rd_data_o)
  );

  logic fault_q, xa_vld_q, rd_vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q  <= 1'b0;
      xa_vld_q <= 1'b0;
      rd_vld_q <= 1'b0;
    end else begin
      fault_q  <= priv_viol;
      xa_vld_q <= xa_en_i;
      rd_vld_q <= is_rd;
    end
  end

  assign set_o    = set_q;
  assign fault_o  = fault_q;
  assign xa_vld_o = xa_vld_q;
  assign rd_vld_o = rd_vld_q;

  // R8
  fault_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> fault_o == $past(dp_en_i && dp_we_i && user_mode_i &&
                                     (dp_win_i ? dp_addr_i[WIN_W-1] : set_o)));
  // R2
  xa_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> xa_vld_o == $past(xa_en_i));
  // R10
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rd_vld_o == $past(dp_en_i && !dp_we_i));
endmodule

// File: tb/xr_dual_set_unit_tb.sv
module xr_dual_set_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned SEED = 32'h5EED_0036;

  logic        clk = 1'b0;
  logic        rst;
  logic        irq_i, setld_en_i, setld_val_i, user_mode_i;
  logic        xa_en_i, xa_inc_i;
  logic [3:0]  xa_num_i;
  logic        dp_en_i, dp_we_i, dp_win_i;
  logic [6:0]  dp_addr_i;
  logic [35:0] dp_wdata_i;
  logic        set_o, xa_vld_o, rd_vld_o, fault_o;
  logic [17:0] xa_ofs_o;
  logic [35:0] rd_data_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  xr_dual_set_unit dut_i (
    .clk(clk), .rst(rst), .irq_i(irq_i), .setld_en_i(setld_en_i),
    .setld_val_i(setld_val_i), .user_mode_i(user_mode_i),
    .xa_en_i(xa_en_i), .xa_num_i(xa_num_i), .xa_inc_i(xa_inc_i),
    .dp_en_i(dp_en_i), .dp_we_i(dp_we_i), .dp_win_i(dp_win_i),
    .dp_addr_i(dp_addr_i), .dp_wdata_i(dp_wdata_i), .set_o(set_o),
    .xa_vld_o(xa_vld_o), .xa_ofs_o(xa_ofs_o), .rd_vld_o(rd_vld_o),
    .rd_data_o(rd_data_o), .fault_o(fault_o)
  );

  int checks = 0;
  int errors = 0;
  logic [35:0] mdl [96];
  bit m_set;

  function automatic int key(bit s, int c, int n);
    if (c == 1 && n < 4) begin c = 0; n = n + 12; end
    return s * 48 + c * 16 + n;
  endfunction

  task automatic chk(string rq, string what, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic idle();
    irq_i = 0; setld_en_i = 0; setld_val_i = 0;
    xa_en_i = 0; xa_inc_i = 0; xa_num_i = 0;
    dp_en_i = 0; dp_we_i = 0; dp_win_i = 0; dp_addr_i = 0; dp_wdata_i = 0;
  endtask

  task automatic run_cycle(string rq_rd, string rq_xa);
    bit cur, exp_set, tset, efault, erd, ewr;
    int c, n, k;
    logic [35:0] erd_data, w;
    logic [17:0] exa;
    cur = m_set;
    exp_set = irq_i ? 1'b1 : (setld_en_i ? setld_val_i : cur);
    tset = dp_win_i ? dp_addr_i[6] : cur;
    c = int'(dp_addr_i[5:4]);
    n = int'(dp_addr_i[3:0]);
    ewr = dp_en_i && dp_we_i;
    erd = dp_en_i && !dp_we_i;
    efault = ewr && user_mode_i && tset;
    erd_data = (c == 3) ? 36'd0 : mdl[key(tset, c, n)];
    exa = mdl[key(cur, 0, int'(xa_num_i))][17:0];
    @(posedge clk);
    @(negedge clk);
    chk("R5", "set_o", 36'(set_o), 36'(exp_set));
    chk("R8", "fault_o", 36'(fault_o), 36'(efault));
    chk("R10", "rd_vld_o", 36'(rd_vld_o), 36'(erd));
    chk("R2", "xa_vld_o", 36'(xa_vld_o), 36'(xa_en_i));
    if (erd) chk(rq_rd, "rd_data_o", rd_data_o, erd_data);
    if (xa_en_i) chk(rq_xa, "xa_ofs_o", 36'(xa_ofs_o), 36'(exa));
    if (xa_en_i && xa_inc_i) begin
      k = key(cur, 0, int'(xa_num_i));
      w = mdl[k];
      mdl[k] = {w[35:18], w[17:0] + w[35:18]};
    end
    if (ewr && !efault && c != 3) mdl[key(tset, c, n)] = dp_wdata_i;
    m_set = exp_set;
    idle();
  endtask

  task automatic wr(bit win, logic [6:0] a, logic [35:0] d);
    dp_en_i = 1; dp_we_i = 1; dp_win_i = win; dp_addr_i = a; dp_wdata_i = d;
  endtask

  task automatic rd(bit win, logic [6:0] a);
    dp_en_i = 1; dp_we_i = 0; dp_win_i = win; dp_addr_i = a;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(SEED));
    idle();
    user_mode_i = 0;
    rst = 1;
    for (int i = 0; i < 96; i++) mdl[i] = '0;
    m_set = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1", "set_o", 36'(set_o), 36'd1);
    chk("R1", "fault_o", 36'(fault_o), 36'd0);
    chk("R1", "xa_vld_o", 36'(xa_vld_o), 36'd0);
    chk("R1", "rd_vld_o", 36'(rd_vld_o), 36'd0);
    rd(1, 7'h25); run_cycle("R1", "R1");
    rd(1, 7'h45); run_cycle("R1", "R1");

    // R3: post-increment with wraparound, step field unchanged
    wr(0, 7'h05, {18'd3, 18'h3FFFF}); run_cycle("R3", "R3");
    xa_en_i = 1; xa_num_i = 5; xa_inc_i = 1; run_cycle("R3", "R3");
    xa_en_i = 1; xa_num_i = 5; run_cycle("R3", "R3");
    rd(0, 7'h05); run_cycle("R3", "R3");

    // R4: aliasing of arithmetic 0..3 and index 12..15
    wr(0, 7'h11, 36'h0_ABCD_1234); run_cycle("R4", "R4");
    rd(0, 7'h0D); run_cycle("R4", "R4");
    wr(0, 7'h0C, 36'h1_2222_3333); run_cycle("R4", "R4");
    rd(0, 7'h10); run_cycle("R4", "R4");
    rd(0, 7'h14); run_cycle("R4", "R4");

    // R9: write beats increment on the same register
    wr(0, 7'h07, 36'h0_0001_0010); run_cycle("R9", "R9");
    xa_en_i = 1; xa_num_i = 7; xa_inc_i = 1;
    wr(0, 7'h07, 36'h5_5555_4444); run_cycle("R9", "R9");
    rd(0, 7'h07); run_cycle("R9", "R9");

    // R5/R6: switch to user set, sets independent
    setld_en_i = 1; setld_val_i = 0; run_cycle("R5", "R5");
    wr(0, 7'h05, 36'h7_0000_0042); run_cycle("R6", "R6");
    rd(1, 7'h45); run_cycle("R6", "R6");
    xa_en_i = 1; xa_num_i = 5; run_cycle("R6", "R6");
    rd(1, 7'h05); run_cycle("R6", "R6");

    // R8: user writes to executive registers fault and are dropped
    user_mode_i = 1;
    wr(1, 7'h47, 36'hF_FFFF_FFFF); run_cycle("R8", "R8");
    run_cycle("R8", "R8");
    rd(1, 7'h47); run_cycle("R8", "R8");
    wr(1, 7'h05, 36'h0_0000_0099); run_cycle("R8", "R8");
    rd(0, 7'h05); run_cycle("R8", "R8");

    // R5: interrupt overrides load
    irq_i = 1; setld_en_i = 1; setld_val_i = 0; run_cycle("R5", "R5");
    wr(0, 7'h21, 36'h1); run_cycle("R8", "R8");
    user_mode_i = 0;

    // R7: class 3 reads zero, writes ignored
    wr(1, 7'h32, 36'h3_1415_9265); run_cycle("R7", "R7");
    rd(1, 7'h32); run_cycle("R7", "R7");
    rd(0, 7'h72); run_cycle("R7", "R7");

    // Random traffic
    for (int it = 0; it < 4000; it++) begin
      user_mode_i = ($urandom % 10) < 3;
      irq_i = ($urandom % 20) == 0;
      setld_en_i = ($urandom % 10) == 0;
      setld_val_i = 1'($urandom);
      xa_en_i = 1'($urandom);
      xa_inc_i = 1'($urandom);
      xa_num_i = 4'($urandom);
      dp_en_i = ($urandom % 4) != 0;
      dp_we_i = 1'($urandom);
      dp_win_i = 1'($urandom);
      dp_addr_i = 7'($urandom);
      dp_wdata_i = {4'($urandom), 32'($urandom)};
      if (($urandom % 8) == 0) dp_wdata_i[35:18] = 18'($urandom % 4);
      run_cycle("R7", "R3");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule